// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a small synchronous static RAM whose data bus can carry a transfer on every clock cycle. Reads and writes may alternate freely, and no idle cycle is needed when the bus changes direction. To make this possible, the write data for a command does not arrive with its address. It arrives in the same bus slot that a read issued in that cycle would use for its result. The block therefore holds each accepted command in a short internal pipeline until its data slot comes round.

A static mode input chooses between two latencies. In flow-through mode the data slot is the cycle right after the command edge, and read data comes straight from the array. In pipelined mode the data slot is one cycle later, and read data passes through an output register. A read that follows a write to the same address sees the written bytes, even when that write has not yet reached the array. The bidirectional data bus is modelled as a data-in port, a data-out port and a drive-enable port. An asynchronous output-enable pin and a sleep input can both silence the drivers.

Top module: `nturn_sram`

## Requirements
- R1: A command is accepted at a rising edge only if cs_a_n is low, cs_b is high, cs_c_n is low and sleep is low. we_n high means read and we_n low means write. If any chip select is inactive, the command is dropped and has no effect on memory or on the bus.
- R2: With pipe_sel low (flow-through), a read accepted at edge k drives the addressed word on dout, with dout_oe high, during the cycle between edges k and k+1.
- R3: With pipe_sel high (pipelined), a read accepted at edge k drives the addressed word on dout, with dout_oe high, during the cycle between edges k+1 and k+2.
- R4: With pipe_sel low, the data for a write accepted at edge k is taken from din at edge k+1.
- R5: With pipe_sel high, the data for a write accepted at edge k is taken from din at edge k+2.
- R6: Writes are per byte. A byte is 9 bits, and byte i occupies din bits 9i+8 down to 9i. Byte i is written only when bw_n[i] is low; the other bytes of the word keep their contents.
- R7: Reads and writes can be issued on consecutive edges in any mix. A read returns every earlier accepted write to its address, merged per byte, including a write whose data is on the bus in the same cycle that the read address is looked up.
- R8: dout_oe is low during the data slot of a write, of a dropped command and of a slot with no command. Whenever dout_oe is low, dout reads all zeros.
- R9: oe_n high forces dout_oe low in the same cycle, with no clock edge needed.
- R10: While sleep is high, commands are dropped and dout_oe is low. Memory contents are kept, so they read back unchanged once sleep is low again.
- R11: While rst_n is low, all in-flight commands are cleared and dout_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_sel | input | 1 | Latency mode: 0 flow-through, 1 pipelined (static) |
| sleep | input | 1 | Standby: drops commands and silences the bus |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| addr | input | AW | Word address |
| we_n | input | 1 | 1 read, 0 write |
| bw_n | input | NB | Byte write enables, active low |
| din | input | NB*9 | Data bus, inward half |
| oe_n | input | 1 | Asynchronous output disable when high |
| dout | output | NB*9 | Data bus, outward half |
| dout_oe | output | 1 | Data bus drive enable |

## Verification
On every cycle the assertions check that oe_n and sleep silence the drivers and that an undriven bus reads zero. They also check that each command's data slot drives or releases the bus at the latency its mode requires. Only the bench scenarios can show that the right bytes arrive: that late write data lands at the right edge and merges per byte, that a read right behind a write sees the new bytes, and that writes which were dropped or issued during sleep leave memory untouched. The scenarios run in both latency modes.

// File: rtl/nturn_pkg.sv
// Shared constants and types for the late-write SRAM.
// Assumes the byte width is fixed at nine bits for every configuration.
package nturn_pkg;
    localparam int BYTE_W = 9;

    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/nturn_cmd_pipe.sv
// Two-stage command delay line. Stage 0 holds the command accepted at the
// last edge and stage 1 the one accepted the edge before. The top module picks
// the stage whose data slot is live, according to the latency mode.
// Assumes the caller has already qualified in_vld with selects and sleep.
module nturn_cmd_pipe #(
    parameter int AW     = 4,
    parameter int NB     = 2,
    parameter int STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_vld,
    input  logic                         in_wr,
    input  logic [AW-1:0]                in_addr,
    input  logic [NB-1:0]                in_be,
    output logic [STAGES-1:0]            st_vld,
    output logic [STAGES-1:0]            st_wr,
    output logic [STAGES-1:0][AW-1:0]    st_addr,
    output logic [STAGES-1:0][NB-1:0]    st_be
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Capture the freshly accepted command.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_vld[g]  <= 1'b0;
                    st_wr[g]   <= 1'b0;
                    st_addr[g] <= '0;
                    st_be[g]   <= '0;
                end else begin
                    st_vld[g]  <= in_vld;
                    st_wr[g]   <= in_wr;
                    st_addr[g] <= in_addr;
                    st_be[g]   <= in_be;
                end
            end
        end else begin : g_tail
            // Shift the command one stage further down the line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_vld[g]  <= 1'b0;
                    st_wr[g]   <= 1'b0;
                    st_addr[g] <= '0;
                    st_be[g]   <= '0;
                end else begin
                    st_vld[g]  <= st_vld[g-1];
                    st_wr[g]   <= st_wr[g-1];
                    st_addr[g] <= st_addr[g-1];
                    st_be[g]   <= st_be[g-1];
                end
            end
        end
    end
endmodule

// File: rtl/nturn_lane_array.sv
// Storage with one independent memory per byte lane, one write port with
// byte enables and one asynchronous read port. Contents are never reset.
module nturn_lane_array
    import nturn_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [NB-1:0]        wbe,
    input  logic [NB*BYTE_W-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic [NB*BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        // Commit this lane's byte when its enable is set.
        always_ff @(posedge clk) begin
            if (we && wbe[b]) begin
                lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/nturn_out_stage.sv
// Read-data path. It merges the write currently in its data slot into the
// looked-up word, keeps the pipelined output register, and gates the bus
// drivers with the asynchronous enable and sleep.
// Assumes pipe_mode is constant outside reset.
module nturn_out_stage
    import nturn_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pipe_mode,
    input  logic                 s0_rd,
    input  logic [AW-1:0]        s0_addr,
    input  logic                 s1_rd,
    input  logic                 s1_wr,
    input  logic [AW-1:0]        s1_addr,
    input  logic [NB-1:0]        s1_be,
    input  logic [NB*BYTE_W-1:0] din,
    input  logic [NB*BYTE_W-1:0] rdata,
    input  logic                 oe_n,
    input  logic                 sleep,
    output logic [NB*BYTE_W-1:0] dout,
    output logic                 dout_oe
);
    localparam int DW = NB * BYTE_W;

    logic [DW-1:0] merged;
    logic [DW-1:0] out_q;
    logic          slot_rd;
    logic [DW-1:0] slot_data;

    for (genvar b = 0; b < NB; b++) begin : g_fwd
        logic hit;
        assign hit = s1_wr && (s1_addr == s0_addr) && s1_be[b];
        assign merged[b*BYTE_W +: BYTE_W] = hit ? din[b*BYTE_W +: BYTE_W]
                                                : rdata[b*BYTE_W +: BYTE_W];
    end

    // Load the output register from a read that is one slot ahead of the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (s0_rd) begin
            out_q <= merged;
        end
    end

    // Choose the read that owns the current data slot and gate the drivers.
    always_comb begin
        slot_rd   = pipe_mode ? s1_rd : s0_rd;
        slot_data = pipe_mode ? out_q : rdata;
        dout_oe   = slot_rd && !oe_n && !sleep;
        dout      = dout_oe ? slot_data : '0;
    end
endmodule

// File: rtl/nturn_sram.sv
// Top level of the zero-turnaround synchronous SRAM. It qualifies commands,
// runs them through the delay line, and commits each write at the edge that
// closes its data slot: one edge late in flow mode, two in pipelined mode.
// Assumes pipe_sel changes only while rst_n is low.
module nturn_sram
    import nturn_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pipe_sel,
    input  logic                 sleep,
    input  logic                 cs_a_n,
    input  logic                 cs_b,
    input  logic                 cs_c_n,
    input  logic [AW-1:0]        addr,
    input  logic                 we_n,
    input  logic [NB-1:0]        bw_n,
    input  logic [NB*BYTE_W-1:0] din,
    input  logic                 oe_n,
    output logic [NB*BYTE_W-1:0] dout,
    output logic                 dout_oe
);
    localparam int DW     = NB * BYTE_W;
    localparam int STAGES = 2;

    logic                      take;
    logic                      pipe_mode;
    logic [STAGES-1:0]         st_vld;
    logic [STAGES-1:0]         st_wr;
    logic [STAGES-1:0][AW-1:0] st_addr;
    logic [STAGES-1:0][NB-1:0] st_be;
    logic                      cm_we;
    logic [AW-1:0]             cm_addr;
    logic [NB-1:0]             cm_be;
    logic [DW-1:0]             rdata;

    assign take      = !cs_a_n && cs_b && !cs_c_n && !sleep;
    assign pipe_mode = (bus_mode_e'(pipe_sel) == MODE_PIPE);

    nturn_cmd_pipe #(.AW(AW), .NB(NB), .STAGES(STAGES)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (take),
        .in_wr   (!we_n),
        .in_addr (addr),
        .in_be   (~bw_n),
        .st_vld  (st_vld),
        .st_wr   (st_wr),
        .st_addr (st_addr),
        .st_be   (st_be)
    );

    // Pick the write whose data slot is the current cycle.
    always_comb begin
        if (pipe_mode) begin
            cm_we   = st_vld[1] && st_wr[1];
            cm_addr = st_addr[1];
            cm_be   = st_be[1];
        end else begin
            cm_we   = st_vld[0] && st_wr[0];
            cm_addr = st_addr[0];
            cm_be   = st_be[0];
        end
    end

    nturn_lane_array #(.AW(AW), .NB(NB)) u_mem (
        .clk   (clk),
        .we    (cm_we),
        .waddr (cm_addr),
        .wbe   (cm_be),
        .wdata (din),
        .raddr (st_addr[0]),
        .rdata (rdata)
    );

    nturn_out_stage #(.AW(AW), .NB(NB)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .s0_rd     (st_vld[0] && !st_wr[0]),
        .s0_addr   (st_addr[0]),
        .s1_rd     (st_vld[1] && !st_wr[1]),
        .s1_wr     (st_vld[1] && st_wr[1]),
        .s1_addr   (st_addr[1]),
        .s1_be     (st_be[1]),
        .din       (din),
        .rdata     (rdata),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );
endmodule

// File: rtl/nturn_sram_chk.sv
// Protocol checker for nturn_sram, bound to every instance. It watches only
// ports and checks bus ownership in each command's data slot.
module nturn_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pipe_sel,
    input logic          sleep,
    input logic          cs_a_n,
    input logic          cs_b,
    input logic          cs_c_n,
    input logic          we_n,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          dout_oe
);
    logic acc;
    assign acc = !cs_a_n && cs_b && !cs_c_n && !sleep;

    // R9: the asynchronous disable always wins
    p_oe_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_oe);

    // R10: a sleeping device never drives the bus
    p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_oe);

    // R8: an undriven bus reads zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));

    // R2: flow-through read owns the next cycle
    p_flow_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && we_n && !pipe_sel) |=> (dout_oe || oe_n || sleep));

    // R3: pipelined read owns the cycle after next
    p_pipe_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && we_n && pipe_sel) |=> ##1 (dout_oe || oe_n || sleep));

    // R8: flow-through slot without a read stays undriven
    p_flow_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((!acc || !we_n) && !pipe_sel) |=> !dout_oe);

    // R8: pipelined slot without a read stays undriven
    p_pipe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((!acc || !we_n) && pipe_sel) |=> ##1 !dout_oe);
endmodule

bind nturn_sram nturn_sram_chk #(.DW(NB * nturn_pkg::BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pipe_sel (pipe_sel),
    .sleep    (sleep),
    .cs_a_n   (cs_a_n),
    .cs_b     (cs_b),
    .cs_c_n   (cs_c_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dout     (dout),
    .dout_oe  (dout_oe)
);

// File: tb/nturn_sram_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the issue task updates a reference memory and queues the
// expected bus state for each data slot; the monitor pops and compares.
module nturn_sram_tb;
    localparam int AW = 4;
    localparam int NB = 2;
    localparam int DW = NB * 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_sel = 1'b0;
    logic          sleep = 1'b0;
    logic          cs_a_n = 1'b1;
    logic          cs_b = 1'b0;
    logic          cs_c_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          we_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic [DW-1:0] din = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    int checks = 0;
    int fails  = 0;
    int ecount = 0;
    bit mon_on = 1'b0;

    logic [DW-1:0] model  [16];
    logic [DW-1:0] din_at [64];
    logic          oe_at  [64];

    int            q_due  [$];
    logic          q_oe   [$];
    logic [DW-1:0] q_data [$];
    string         q_tag  [$];

    nturn_sram #(.AW(AW), .NB(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .sleep(sleep),
        .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .addr(addr),
        .we_n(we_n), .bw_n(bw_n), .din(din), .oe_n(oe_n),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #10 clk = ~clk;

    always @(posedge clk) ecount <= ecount + 1;

    // Present scheduled write data and output-disable for the current slot.
    always @(negedge clk) begin
        din = din_at[ecount % 64];
        oe_n = oe_at[ecount % 64];
        oe_at[ecount % 64] = 1'b0;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare the bus against every item due in this slot.
    always @(negedge clk) begin
        #2;
        if (mon_on) begin
            while (q_due.size() > 0 && q_due[0] <= ecount) begin
                if (q_due[0] < ecount) begin
                    chk(1'b0, {q_tag[0], " missed slot"}, DW'(ecount), DW'(q_due[0]));
                end else begin
                    chk(dout_oe == q_oe[0], {q_tag[0], " oe"},
                        DW'(dout_oe), DW'(q_oe[0]));
                    chk(dout == q_data[0], {q_tag[0], " data"}, dout, q_data[0]);
                end
                void'(q_due.pop_front());
                void'(q_oe.pop_front());
                void'(q_data.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    // kind: 0 idle, 1 read, 2 write, 3/4/5 drop by cs_a_n/cs_b/cs_c_n,
    // 6 read during sleep, 7 write during sleep
    task automatic issue(input int kind, input logic [AW-1:0] a,
                         input logic [NB-1:0] bwn, input logic [DW-1:0] d,
                         input bit mask, input string tag);
        int slot;
        @(negedge clk);
        slot = ecount + 1 + (pipe_sel ? 1 : 0);
        addr   = a;
        bw_n   = bwn;
        we_n   = !(kind == 2 || kind == 3 || kind == 5 || kind == 7);
        cs_a_n = (kind == 0 || kind == 3);
        cs_b   = !(kind == 0 || kind == 4);
        cs_c_n = (kind == 0 || kind == 5);
        sleep  = (kind == 6 || kind == 7);
        q_due.push_back(slot);
        q_tag.push_back(tag);
        if (kind == 2) begin
            for (int b = 0; b < NB; b++)
                if (!bwn[b]) model[a][b*9 +: 9] = d[b*9 +: 9];
            din_at[slot % 64] = d;
            q_oe.push_back(1'b0);
            q_data.push_back('0);
        end else if (kind == 1 && !mask) begin
            q_oe.push_back(1'b1);
            q_data.push_back(model[a]);
        end else begin
            if (kind == 1) oe_at[slot % 64] = 1'b1;
            q_oe.push_back(1'b0);
            q_data.push_back('0);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) issue(0, '0, '1, '0, 1'b0, "R8 idle");
        repeat (3) @(negedge clk);
    endtask

    task automatic run_mode(input bit m);
        string rd;
        string wr;
        logic [DW-1:0] v;
        rd = m ? "R3 read" : "R2 read";
        wr = m ? "R5 write" : "R4 write";
        @(negedge clk);
        rst_n = 1'b0;
        pipe_sel = m;
        repeat (3) @(negedge clk);
        #2;
        chk(dout_oe == 1'b0, "R11 reset oe", DW'(dout_oe), '0);
        @(negedge clk);
        rst_n = 1'b1;
        // full-word writes, then reads
        for (int a = 0; a < 8; a++) begin
            v = DW'((a * 18'h0b6d3) ^ (m ? 18'h2a5a5 : 18'h15a5a));
            issue(2, AW'(a), 2'b00, v, 1'b0, wr);
        end
        for (int a = 0; a < 8; a++) issue(1, AW'(a), '1, '0, 1'b0, rd);
        // read right behind write to the same address (R7)
        for (int a = 8; a < 12; a++) begin
            v = DW'(18'h3c0f0 + a + (m ? 18'h00100 : 18'h0));
            issue(2, AW'(a), 2'b00, v, 1'b0, "R7 write");
            issue(1, AW'(a), '1, '0, 1'b0, "R7 read after write");
            issue(1, AW'(a), '1, '0, 1'b0, "R7 second read");
        end
        // byte-lane writes (R6)
        issue(2, 4'd3, 2'b10, 18'h3ffff, 1'b0, "R6 low byte write");
        issue(1, 4'd3, '1, '0, 1'b0, "R6 low byte merge");
        issue(2, 4'd3, 2'b01, 18'h00000, 1'b0, "R6 high byte write");
        issue(1, 4'd3, '1, '0, 1'b0, "R6 high byte merge");
        issue(2, 4'd4, 2'b11, 18'h12345, 1'b0, "R6 no-byte write");
        issue(1, 4'd4, '1, '0, 1'b0, "R6 untouched word");
        // mixed alternation (R7)
        issue(1, 4'd0, '1, '0, 1'b0, "R7 mix read");
        issue(2, 4'd1, 2'b00, 18'h0aaaa, 1'b0, "R7 mix write");
        issue(1, 4'd2, '1, '0, 1'b0, "R7 mix read");
        issue(2, 4'd2, 2'b00, 18'h15555, 1'b0, "R7 mix write");
        issue(1, 4'd1, '1, '0, 1'b0, "R7 mix read");
        issue(1, 4'd2, '1, '0, 1'b0, "R7 mix read");
        // dropped commands by each select (R1)
        issue(3, 4'd5, 2'b00, 18'h00bad, 1'b0, "R1 drop cs_a_n");
        issue(4, 4'd5, 2'b00, 18'h00bad, 1'b0, "R1 drop cs_b");
        issue(5, 4'd5, 2'b00, 18'h00bad, 1'b0, "R1 drop cs_c_n");
        issue(0, 4'd5, '1, '0, 1'b0, "R1 idle");
        issue(1, 4'd5, '1, '0, 1'b0, "R1 content kept");
        // asynchronous output disable (R9)
        issue(1, 4'd6, '1, '0, 1'b1, "R9 masked read");
        issue(1, 4'd6, '1, '0, 1'b0, "R9 unmasked read");
        // sleep (R10)
        issue(0, '0, '1, '0, 1'b0, "R8 idle");
        issue(0, '0, '1, '0, 1'b0, "R8 idle");
        issue(7, 4'd7, 2'b00, 18'h00bad, 1'b0, "R10 sleep write");
        issue(6, 4'd7, '1, '0, 1'b0, "R10 sleep read");
        issue(0, '0, '1, '0, 1'b0, "R10 idle");
        issue(0, '0, '1, '0, 1'b0, "R10 idle");
        issue(1, 4'd7, '1, '0, 1'b0, "R10 content kept");
        drain();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            din_at[i] = '0;
            oe_at[i] = 1'b0;
        end
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (2) @(negedge clk);
        mon_on = 1'b1;
        run_mode(1'b0);
        run_mode(1'b1);
        chk(q_due.size() == 0, "R8 queue empty", DW'(q_due.size()), '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", ecount);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule